// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Arbiter

This block keeps every row of a multiplexed-address DRAM refreshed while an access controller shares the same row strobe, column strobe and address pins. A free-running timebase raises one owed refresh every `INTERVAL` clock cycles. With the default 2048 rows and a 32 ms retention window, the interval is 32 ms / 2048, which is about 781 cycles at 50 MHz. A slower interval suits parts that can hold data over 128 ms. Owed refreshes are counted up to `MAX_OWED`. A refresh is granted only when the access controller reports its row strobe idle and its precharge complete. While the access controller still has work pending, owed refreshes are postponed until the count saturates. At that point new accesses are held off.

Each refresh is either column-before-row, which relies on the DRAM's own row counter, or row-only, which drives a row address from a counter kept in this block and wrapping at `ROWS`. A level request moves the memory into low-power self-refresh. Before entering, the block runs a burst that covers every row, then holds both strobes low. After leaving and a recovery precharge, it runs a second full burst, so that the coverage rule holds on both sides of self-refresh.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and right after reset, `busy`, `acc_block` and `sr_active` are low, both strobes and `ref_we_n` are high, and `ref_addr` is zero.
- R2: Outside a self-refresh flow, one refresh becomes owed every `INTERVAL` cycles. The owed count never exceeds `MAX_OWED`, and a tick at saturation is dropped.
- R3: A refresh starts only from the idle state in a cycle where `acc_idle` is 1. While `acc_req` is 1, a refresh starts only if the owed count has reached `MAX_OWED`. `acc_block` is 1 whenever the owed count equals `MAX_OWED`.
- R4: With `ras_only` = 0 at the grant, the block drives the refresh as follows: column strobe low with row strobe high for `T_CSR` cycles, then both low for `T_RAS` cycles, then both high for `T_RP` cycles. `ref_we_n` stays 1 and `ref_addr` is 0 throughout.
- R5: With `ras_only` = 1 at the grant, the timing is the same as R4 but the column strobe stays high. `ref_addr` carries the row counter during the setup and strobe cycles. The counter advances by one per refresh and wraps from `ROWS`-1 to 0.
- R6: Each completed refresh outside a self-refresh flow lowers the owed count by one, at the end of its strobe phase.
- R7: `sr_req` = 1, sampled in the idle state with `acc_idle` = 1, takes priority over owed refreshes and starts a flow with these steps:
  - `ROWS` back-to-back refreshes;
  - `T_CSR` cycles of column strobe low;
  - then both strobes low with `sr_active` = 1, for at least `T_SELF_MIN` cycles and until `sr_req` is 0.
- R8: After self-refresh, both strobes stay high for `T_RPS` cycles, then `ROWS` refreshes follow. The block then goes idle with the owed count and the timebase cleared.
- R9: `busy` is 1 exactly while the block owns the pins, and `acc_block` is 1 whenever `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only | input | 1 | Refresh style sampled at each grant: 1 row-only, 0 column-before-row |
| acc_idle | input | 1 | Access controller has its row strobe idle and precharge done |
| acc_req | input | 1 | Access controller has work pending |
| sr_req | input | 1 | Level request for self-refresh |
| ref_ras_n | output | 1 | Row strobe override |
| ref_cas_n | output | 1 | Column strobe override |
| ref_we_n | output | 1 | Write enable override, held high |
| ref_addr | output | $clog2(ROWS) | Row address for row-only refresh |
| busy | output | 1 | Block owns the DRAM pins |
| acc_block | output | 1 | Access controller must not start a cycle |
| sr_active | output | 1 | Memory is held in self-refresh |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|---|---|
| `ROWS` | 8 |
| `INTERVAL` | 20 |
| `MAX_OWED` | 3 |
| `T_CSR` | 2 |
| `T_RAS` | 3 |
| `T_RP` | 2 |
| `T_SELF_MIN` | 6 |
| `T_RPS` | 4 |

With eight rows, the row counter wraps several times, and both full bursts around self-refresh finish in a few dozen cycles. A short interval with a postponement limit of three lets a busy access controller drive the owed count to saturation within about sixty cycles. A six-cycle minimum self-refresh width lets a request that drops early be seen stretched to that minimum.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROWS       = 2048,
  parameter int INTERVAL   = 781,
  parameter int MAX_OWED   = 8,
  parameter int T_CSR      = 2,
  parameter int T_RAS      = 4,
  parameter int T_RP       = 3,
  parameter int T_SELF_MIN = 5000,
  parameter int T_RPS      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ras_only,
  input  logic                    acc_idle,
  input  logic                    acc_req,
  input  logic                    sr_req,
  output logic                    ref_ras_n,
  output logic                    ref_cas_n,
  output logic                    ref_we_n,
  output logic [$clog2(ROWS)-1:0] ref_addr,
  output logic                    busy,
  output logic                    acc_block,
  output logic                    sr_active
);
  localparam int AW  = $clog2(ROWS);
  localparam int BW  = $clog2(ROWS + 1);
  localparam int TBW = $clog2(INTERVAL);
  localparam int OW  = $clog2(MAX_OWED + 1);
  localparam int TW  = $clog2(T_CSR + T_RAS + T_RP + T_SELF_MIN + T_RPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_PRECH, S_SSET, S_SELF, S_SREC} st_t;

  st_t           st;
  logic [TW-1:0] tcnt;
  logic [TBW-1:0] tb;
  logic [OW-1:0] owed;
  logic [BW-1:0] burst;
  logic [AW-1:0] row;
  logic          rmode, entering, flow;

  wire done  = (tcnt == '0);
  wire tick  = !flow && (tb == TBW'(INTERVAL - 1));
  wire dec   = !flow && st == S_STROBE && done;
  wire sat   = (owed == OW'(MAX_OWED));
  wire cyc   = (st == S_SETUP) || (st == S_STROBE);
  wire grant = (owed != '0) && (!acc_req || sat);

  assign ref_ras_n = !(st == S_STROBE || st == S_SELF);
  assign ref_cas_n = !((cyc && !rmode) || st == S_SSET || st == S_SELF);
  assign ref_we_n  = 1'b1;
  assign ref_addr  = (cyc && rmode) ? row : '0;
  assign busy      = (st != S_IDLE);
  assign sr_active = (st == S_SELF);
  assign acc_block = busy || sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; burst <= '0; row <= '0;
      rmode <= 1'b0; entering <= 1'b0; flow <= 1'b0;
    end else begin
      if (!done) tcnt <= tcnt - 1'b1;
      case (st)
        S_IDLE: if (acc_idle && (sr_req || grant)) begin
          st <= S_SETUP; tcnt <= TW'(T_CSR - 1); rmode <= ras_only;
          if (sr_req) begin
            burst <= BW'(ROWS); entering <= 1'b1; flow <= 1'b1;
          end
        end
        S_SETUP: if (done) begin st <= S_STROBE; tcnt <= TW'(T_RAS - 1); end
        S_STROBE: if (done) begin
          st <= S_PRECH; tcnt <= TW'(T_RP - 1);
          if (rmode) row <= (row == AW'(ROWS - 1)) ? '0 : row + 1'b1;
          if (burst != '0) burst <= burst - 1'b1;
        end
        S_PRECH: if (done) begin
          if (burst != '0) begin
            st <= S_SETUP; tcnt <= TW'(T_CSR - 1);
          end else if (entering) begin
            st <= S_SSET; tcnt <= TW'(T_CSR - 1); entering <= 1'b0;
          end else begin
            st <= S_IDLE; flow <= 1'b0;
          end
        end
        S_SSET: if (done) begin st <= S_SELF; tcnt <= TW'(T_SELF_MIN - 1); end
        S_SELF: if (done && !sr_req) begin st <= S_SREC; tcnt <= TW'(T_RPS - 1); end
        S_SREC: if (done) begin
          st <= S_SETUP; tcnt <= TW'(T_CSR - 1); burst <= BW'(ROWS); rmode <= ras_only;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb <= '0; owed <= '0;
    end else if (flow) begin
      tb <= '0;
      if (st == S_PRECH && done && burst == '0 && !entering) owed <= '0;
    end else begin
      tb <= tick ? '0 : tb + 1'b1;
      if (tick && !dec && !sat) owed <= owed + 1'b1;
      else if (!tick && dec) owed <= owed - 1'b1;
    end
  end

  a_r2_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));
  a_r3_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc_idle));
  a_r4_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ref_ras_n) && !ref_cas_n) |-> ($past(!ref_cas_n) && ref_we_n));
  a_r5_row_only_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ref_ras_n) && ref_cas_n) |-> ($stable(ref_addr) && rmode));
  a_r8_exit_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (ref_ras_n && ref_cas_n));
  a_r9_block_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> acc_block);
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8, INTERVAL = 20, MAX_OWED = 3;
  localparam int T_CSR = 2, T_RAS = 3, T_RP = 2, T_SELF_MIN = 6, T_RPS = 4;
  localparam int AW = $clog2(ROWS);

  logic clk = 0, rst_n = 0;
  logic ras_only = 0, acc_idle = 0, acc_req = 0, sr_req = 0;
  logic ref_ras_n, ref_cas_n, ref_we_n, busy, acc_block, sr_active;
  logic [AW-1:0] ref_addr;

  dram_refresh_sched #(.ROWS(ROWS), .INTERVAL(INTERVAL), .MAX_OWED(MAX_OWED),
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_SELF_MIN(T_SELF_MIN), .T_RPS(T_RPS)) uut (
    .clk(clk), .rst_n(rst_n), .ras_only(ras_only), .acc_idle(acc_idle), .acc_req(acc_req),
    .sr_req(sr_req), .ref_ras_n(ref_ras_n), .ref_cas_n(ref_cas_n), .ref_we_n(ref_we_n),
    .ref_addr(ref_addr), .busy(busy), .acc_block(acc_block), .sr_active(sr_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic idle; logic self; logic dec; logic rm;
    logic ras_n; logic cas_n; logic [AW-1:0] addr; logic [3:0] req;
  } ent_t;

  ent_t q[$];
  ent_t cur;
  int owed, tb, row, self_n, tests, fails, self_seen;
  bit flow, in_self, pend_self, checking;

  function automatic ent_t mk(bit idle, bit self, bit dec, bit rm, bit ras_n, bit cas_n, int addr, int rq);
    ent_t e;
    e.idle = idle; e.self = self; e.dec = dec; e.rm = rm;
    e.ras_n = ras_n; e.cas_n = cas_n; e.addr = AW'(addr); e.req = 4'(rq);
    return e;
  endfunction

  task automatic push_ref(bit m, int a, int rq);
    for (int i = 0; i < T_CSR; i++) q.push_back(mk(0, 0, 0, m, 1, m, m ? a : 0, rq));
    for (int i = 0; i < T_RAS; i++) q.push_back(mk(0, 0, 0, m, 0, m, m ? a : 0, rq));
    for (int i = 0; i < T_RP; i++)  q.push_back(mk(0, 0, i == 0, m, 1, 1, 0, rq));
  endtask

  task automatic push_burst(bit m, int rq);
    for (int k = 0; k < ROWS; k++) push_ref(m, (row + k) % ROWS, rq);
  endtask

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit pflow, dec, clr;
    if (!rst_n) begin
      q.delete(); cur = mk(1, 0, 0, 0, 1, 1, 0, 1);
      owed = 0; tb = 0; row = 0; flow = 0; in_self = 0; pend_self = 0; self_n = 0;
    end else begin
      pflow = flow; dec = 0; clr = 0;
      if (q.size() > 0) begin
        cur = q.pop_front();
        if (cur.dec) begin
          dec = !pflow;
          if (cur.rm) row = (row + 1) % ROWS;
        end
      end else if (in_self) begin
        if (self_n >= T_SELF_MIN && !sr_req) begin
          in_self = 0;
          for (int i = 0; i < T_RPS; i++) q.push_back(mk(0, 0, 0, 0, 1, 1, 0, 8));
          push_burst(ras_only, 8);
          cur = q.pop_front();
        end else self_n++;
      end else if (pend_self) begin
        pend_self = 0; in_self = 1; self_n = 1;
        cur = mk(0, 1, 0, 0, 0, 0, 0, 7);
      end else if (!cur.idle) begin
        cur = mk(1, 0, 0, 0, 1, 1, 0, 3);
        if (pflow) begin flow = 0; clr = 1; end
      end else if (acc_idle) begin
        if (sr_req) begin
          flow = 1; pend_self = 1;
          push_burst(ras_only, 7);
          for (int i = 0; i < T_CSR; i++) q.push_back(mk(0, 0, 0, 0, 1, 0, 0, 7));
          cur = q.pop_front();
        end else if (owed > 0 && (!acc_req || owed >= MAX_OWED)) begin
          push_ref(ras_only, row, ras_only ? 5 : 4);
          cur = q.pop_front();
        end
      end
      if (pflow) begin
        tb = 0;
        if (clr) owed = 0;
      end else begin
        bit tick;
        tick = (tb == INTERVAL - 1);
        tb = tick ? 0 : tb + 1;
        owed = owed + int'(tick) - int'(dec);
        if (owed > MAX_OWED) owed = MAX_OWED;
      end
    end
  end

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking && rst_n) begin
    string rq;
    int pa, pe;
    rq = $sformatf("R%0d", cur.req);
    pa = {ref_ras_n, ref_cas_n, ref_we_n, ref_addr};
    pe = {cur.ras_n, cur.cas_n, 1'b1, cur.addr};
    chk(pa == pe, rq, "pins {ras,cas,we,addr}", pa, pe);                       // R4 R5 R7 R8
    chk({busy, sr_active} == {!cur.idle, cur.self}, "R9 R7", "{busy,sr_active}",
        {busy, sr_active}, {!cur.idle, cur.self});
    chk(acc_block == (!cur.idle || owed >= MAX_OWED), "R2 R3 R6", "acc_block",
        acc_block, (!cur.idle || owed >= MAX_OWED));
    if (sr_active) self_seen++;
  end

  task automatic run(int n, bit rnd_idle, bit rnd_req, bit rnd_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd_idle) acc_idle = ($urandom_range(0, 3) != 0);
      if (rnd_req)  acc_req  = $urandom_range(0, 1);
      if (rnd_mode && !busy) ras_only = $urandom_range(0, 1);
    end
  endtask

  initial begin
    int guard;
    tests = 0; fails = 0; self_seen = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({busy, acc_block, sr_active} == 3'b000, "R1", "flags in reset", {busy, acc_block, sr_active}, 0);
    chk({ref_ras_n, ref_cas_n, ref_we_n} == 3'b111 && ref_addr == '0, "R1", "pins in reset",
        {ref_ras_n, ref_cas_n, ref_we_n, ref_addr}, {3'b111, AW'(0)});
    rst_n = 1; checking = 1;
    @(negedge clk);
    chk(!busy && !acc_block, "R1", "flags after reset", {busy, acc_block}, 0);
    acc_idle = 1; ras_only = 0;
    run(300, 0, 0, 0);                         // R4 plain CBR refreshing
    ras_only = 1; run(400, 0, 0, 0);           // R5 row counter wraps
    acc_req = 1; run(300, 0, 0, 0);            // R3 postponement until saturation
    run(600, 1, 1, 1);                         // mixed traffic
    acc_idle = 0; acc_req = 1; run(200, 0, 0, 0);   // R2 saturation
    acc_idle = 1; acc_req = 0; run(100, 0, 0, 0);
    ras_only = 0; sr_req = 1; run(300, 0, 0, 0);    // R7 long self-refresh
    sr_req = 0; run(200, 0, 0, 0);                  // R8 exit sequence
    chk(self_seen >= T_SELF_MIN, "R7", "self-refresh cycles seen", self_seen, T_SELF_MIN);
    ras_only = 1; sr_req = 1; guard = 0;
    while (!sr_active && guard < 500) begin @(negedge clk); guard++; end
    chk(sr_active, "R7", "self-refresh reached", sr_active, 1);
    sr_req = 0; run(3, 0, 0, 0);
    chk(sr_active, "R7", "held for minimum width", sr_active, 1);
    run(200, 0, 0, 0);
    run(500, 1, 1, 1);
    checking = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule